// File: doc/BRIEF.md
# Multi-mode programmable down-counter channel

This block is one 16-bit down-counter channel. It has a count-clock enable, a gate input and a single output. Six operating modes shape the output waveform from a programmed initial count and the gate. The modes are: a level that rises at terminal count, a retriggerable one-shot pulse, a periodic rate pulse, a square wave, a strobe started by software, and a strobe started by the gate. Counting runs in binary or in four-digit BCD.

The host selects a mode and the number format with a configuration strobe. The host then writes the initial count one byte at a time: first the low byte, then the high byte. Writing the high byte commits the count. The count clock is an enable pulse inside the system clock domain, and each pulse stands for one falling edge of the counter clock. The live count and the output level are visible at all times.

Top module: `ctr_channel`

## Requirements
- R1: After reset the output is high, the count reads 0, and nothing counts until a mode and a count have been written.
- R2: In mode code 0, writing the mode drives the output low. Committing a count of N also drives the output low. The first count tick after the commit loads N, and the output rises on the Nth tick after that. It then stays high while the count keeps decrementing and wraps.
- R3: In mode code 0, a low-byte write freezes the count. The high-byte write that follows commits the new count, and counting restarts from it.
- R4: In mode code 0, ticks that arrive while the gate is low do not change a loaded count.
- R5: In mode code 1, the output idles high. The first tick after a rising gate edge loads the count and drives the output low. The output rises N ticks later. A new rising edge restarts the full count. A count written during the pulse does not shorten it.
- R6: In mode code 2, the output is low for exactly one tick in every N ticks. A count committed mid-period takes effect only at the next reload.
- R7: In mode codes 2 and 3, a low gate forces the output high one system clock later and holds the count. The first tick after a rising gate edge reloads the initial count.
- R8: In mode code 3, an even N gives N/2 ticks high and N/2 ticks low. An odd N gives (N+1)/2 ticks high and (N-1)/2 ticks low.
- R9: In mode code 4, the output is high after the mode is written. The tick after a commit loads the count. The output is low for exactly one tick when the count reaches 0. Ticks with the gate low do not count.
- R10: In mode code 5, the first tick after a rising gate edge loads the count. The output is low for exactly one tick at terminal count. A new rising edge restarts the count.
- R11: When the configuration BCD bit is 1, the count holds four BCD digits (nibble 0 is the units digit) and decrements decimally. An initial count of 0 counts as 10000 in BCD and as 65536 in binary.
- R12: Mode codes 6 and 7 behave exactly as codes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | One-cycle enable marking a counter clock falling edge |
| gate_in | input | 1 | Gate level, synchronous to clk |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Mode code 0..7 |
| cfg_bcd | input | 1 | 1 selects BCD counting |
| ld_lo | input | 1 | Low-byte count write strobe |
| ld_hi | input | 1 | High-byte count write strobe; commits the count |
| ld_byte | input | 8 | Count byte data |
| count_o | output | 16 | Live counting-element value |
| out_o | output | 1 | Channel output |

## Verification
The assertions assume four things about the inputs. Host writes and count ticks never share a system clock cycle. The gate is already synchronous. Only one write strobe is active in any cycle. In BCD mode, every committed count is made of valid decimal digits. The stimulus honours all of these: each tick is one cycle wide with an idle cycle after it, every configuration or byte write sits in its own cycle between ticks, and the BCD scenarios write only decimal nibbles.

// File: rtl/ctr_channel_pkg.sv
package ctr_channel_pkg;

   typedef enum logic [2:0] {
      MD_TC_LEVEL  = 3'd0,
      MD_ONE_SHOT  = 3'd1,
      MD_RATE      = 3'd2,
      MD_SQUARE    = 3'd3,
      MD_SW_STROBE = 3'd4,
      MD_HW_STROBE = 3'd5
   } ctr_mode_e;

   // codes with bit 1 set ignore bit 2
   function automatic ctr_mode_e fold_mode(input logic [2:0] code);
      if (code[1]) return ctr_mode_e'({1'b0, code[1:0]});
      return ctr_mode_e'(code);
   endfunction

   function automatic logic mode_idles_high(input ctr_mode_e m);
      return (m != MD_TC_LEVEL);
   endfunction

endpackage

// File: rtl/ctr_gate_edge.sv
module ctr_gate_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_in,
   input  logic tick,
   input  logic clr,
   output logic trig_o
);
   logic gate_q;
   logic pend_q;

   // a rising edge seen in the tick cycle itself also counts
   assign trig_o = pend_q | (gate_in & ~gate_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         gate_q <= gate_in;
         if (clr || tick) pend_q <= 1'b0;
         else             pend_q <= trig_o;
      end
   end
endmodule

// File: rtl/ctr_decrement.sv
module ctr_decrement #(
   parameter int CNT_W = 16
) (
   input  logic [CNT_W-1:0] val,
   input  logic [1:0]       amt,
   input  logic             bcd,
   output logic [CNT_W-1:0] nxt_o,
   output logic             zero_o
);
   localparam int DIGITS = CNT_W / 4;

   logic [CNT_W-1:0] bin_res;
   logic [CNT_W-1:0] bcd_res;
   logic [1:0]       sub [DIGITS];

   if (CNT_W % 4 != 0) begin : g_bad_width
      initial $error("ctr_decrement: CNT_W must be a multiple of 4");
   end

   assign bin_res = val - {{(CNT_W-2){1'b0}}, amt};
   assign sub[0]  = amt;

   for (genvar i = 0; i < DIGITS; i++) begin : g_digit
      logic [3:0] dig;
      logic       under;
      assign dig   = val[4*i +: 4];
      assign under = (dig < {2'b00, sub[i]});
      assign bcd_res[4*i +: 4] = under ? (dig + 4'd10 - {2'b00, sub[i]})
                                       : (dig - {2'b00, sub[i]});
      if (i < DIGITS - 1) begin : g_borrow
         assign sub[i+1] = {1'b0, under};
      end
   end

   assign nxt_o  = bcd ? bcd_res : bin_res;
   assign zero_o = (nxt_o == '0);
endmodule

// File: rtl/ctr_count_reg.sv
module ctr_count_reg #(
   parameter int CNT_W = 16,
   localparam int BYTE_W = CNT_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [CNT_W-1:0]  cnt_o
);
   logic [BYTE_W-1:0] lo_q;
   logic [CNT_W-1:0]  cr_q;

   if (CNT_W % 2 != 0) begin : g_bad_width
      initial $error("ctr_count_reg: CNT_W must be even");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= '0;
         cr_q <= '0;
      end else begin
         if (wr_lo) lo_q <= wr_data;
         if (wr_hi) cr_q <= {wr_data, lo_q};
      end
   end

   assign cnt_o = cr_q;
endmodule

// File: rtl/ctr_channel.sv
module ctr_channel
   import ctr_channel_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter bit BCD_EN = 1'b1,
   localparam int BYTE_W = CNT_W / 2,
   localparam int DIGITS = CNT_W / 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_tick,
   input  logic              gate_in,
   input  logic              cfg_wr,
   input  logic [2:0]        cfg_mode,
   input  logic              cfg_bcd,
   input  logic              ld_lo,
   input  logic              ld_hi,
   input  logic [BYTE_W-1:0] ld_byte,
   output logic [CNT_W-1:0]  count_o,
   output logic              out_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 8 || CNT_W % 8 != 0) begin : g_bad_width
      initial $error("ctr_channel: CNT_W must be a positive multiple of 8");
   end

   ctr_mode_e        mode_q;
   ctr_mode_e        mode_new;
   logic             bcd_q, bcd_eff;
   logic             out_q, pend_q, valid_q, run_q, halt_q, armed_q;
   logic [CNT_W-1:0] ce_q, cr_w, nxt_w;
   logic             zero_w, trig_w, periodic;
   logic [1:0]       step_w;

   assign mode_new = fold_mode(cfg_mode);
   assign periodic = (mode_q == MD_RATE) || (mode_q == MD_SQUARE);

   if (BCD_EN) begin : g_bcd_on
      assign bcd_eff = bcd_q;
   end else begin : g_bcd_off
      assign bcd_eff = 1'b0;
   end

   ctr_gate_edge u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .gate_in (gate_in),
      .tick    (cnt_tick),
      .clr     (cfg_wr),
      .trig_o  (trig_w)
   );

   ctr_count_reg #(.CNT_W(CNT_W)) u_creg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lo   (ld_lo),
      .wr_hi   (ld_hi),
      .wr_data (ld_byte),
      .cnt_o   (cr_w)
   );

   // square wave: odd value takes 1 while high, 3 while low; else 2
   always_comb begin
      if (mode_q == MD_SQUARE) begin
         if (ce_q[0]) step_w = out_q ? 2'd1 : 2'd3;
         else         step_w = 2'd2;
      end else begin
         step_w = 2'd1;
      end
   end

   ctr_decrement #(.CNT_W(CNT_W)) u_dec (
      .val    (ce_q),
      .amt    (step_w),
      .bcd    (bcd_eff),
      .nxt_o  (nxt_w),
      .zero_o (zero_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= MD_TC_LEVEL;
         bcd_q   <= 1'b0;
         out_q   <= 1'b1;
         ce_q    <= '0;
         pend_q  <= 1'b0;
         valid_q <= 1'b0;
         run_q   <= 1'b0;
         halt_q  <= 1'b0;
         armed_q <= 1'b0;
      end else if (cfg_wr) begin
         mode_q  <= mode_new;
         bcd_q   <= cfg_bcd;
         out_q   <= mode_idles_high(mode_new);
         pend_q  <= 1'b0;
         valid_q <= 1'b0;
         run_q   <= 1'b0;
         halt_q  <= 1'b0;
         armed_q <= 1'b0;
      end else if (ld_lo || ld_hi) begin
         if (ld_lo && mode_q == MD_TC_LEVEL) halt_q <= 1'b1;
         if (ld_hi) begin
            pend_q  <= 1'b1;
            valid_q <= 1'b1;
            halt_q  <= 1'b0;
            if (mode_q == MD_TC_LEVEL) out_q <= 1'b0;
         end
      end else begin
         if (periodic && !gate_in) out_q <= 1'b1;
         if (cnt_tick) begin
            case (mode_q)
               MD_TC_LEVEL: begin
                  if (pend_q) begin
                     ce_q   <= cr_w;
                     pend_q <= 1'b0;
                     run_q  <= 1'b1;
                  end else if (run_q && !halt_q && gate_in) begin
                     ce_q <= nxt_w;
                     if (zero_w) out_q <= 1'b1;
                  end
               end
               MD_ONE_SHOT: begin
                  if (trig_w && valid_q) begin
                     ce_q   <= cr_w;
                     out_q  <= 1'b0;
                     run_q  <= 1'b1;
                     pend_q <= 1'b0;
                  end else if (run_q) begin
                     ce_q <= nxt_w;
                     if (zero_w) out_q <= 1'b1;
                  end
               end
               MD_RATE: begin
                  if (gate_in && valid_q && (trig_w || !run_q)) begin
                     ce_q   <= cr_w;
                     out_q  <= 1'b1;
                     run_q  <= 1'b1;
                     pend_q <= 1'b0;
                  end else if (gate_in && run_q) begin
                     if (ce_q == ONE) begin
                        ce_q  <= cr_w;
                        out_q <= 1'b1;
                     end else begin
                        ce_q <= nxt_w;
                        if (nxt_w == ONE) out_q <= 1'b0;
                     end
                  end
               end
               MD_SQUARE: begin
                  if (gate_in && valid_q && (trig_w || !run_q)) begin
                     ce_q   <= cr_w;
                     out_q  <= 1'b1;
                     run_q  <= 1'b1;
                     pend_q <= 1'b0;
                  end else if (gate_in && run_q) begin
                     if (zero_w) begin
                        ce_q  <= cr_w;
                        out_q <= ~out_q;
                     end else begin
                        ce_q <= nxt_w;
                     end
                  end
               end
               MD_SW_STROBE: begin
                  if (!out_q) out_q <= 1'b1;
                  if (pend_q) begin
                     ce_q    <= cr_w;
                     pend_q  <= 1'b0;
                     run_q   <= 1'b1;
                     armed_q <= 1'b1;
                  end else if (run_q && gate_in) begin
                     ce_q <= nxt_w;
                     if (zero_w && armed_q) begin
                        out_q   <= 1'b0;
                        armed_q <= 1'b0;
                     end
                  end
               end
               MD_HW_STROBE: begin
                  if (!out_q) out_q <= 1'b1;
                  if (trig_w && valid_q) begin
                     ce_q    <= cr_w;
                     run_q   <= 1'b1;
                     armed_q <= 1'b1;
                     pend_q  <= 1'b0;
                  end else if (run_q) begin
                     ce_q <= nxt_w;
                     if (zero_w && armed_q) begin
                        out_q   <= 1'b0;
                        armed_q <= 1'b0;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign count_o = ce_q;
   assign out_o   = out_q;

   function automatic logic digits_ok(input logic [CNT_W-1:0] v);
      for (int i = 0; i < DIGITS; i++)
         if (v[4*i +: 4] > 4'd9) return 1'b0;
      return 1'b1;
   endfunction

   logic host_quiet;
   assign host_quiet = !cfg_wr && !ld_lo && !ld_hi;

   // R2: selecting the level mode pulls the output low
   p_level_mode_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && mode_new == MD_TC_LEVEL) |=> !out_o);

   // R2: once high in the level mode, only a host write lowers it
   p_level_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_TC_LEVEL && out_o && host_quiet) |=> out_o);

   // R6: rate pulse lasts one tick
   p_rate_low_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_RATE && !out_o && cnt_tick && host_quiet) |=> out_o);

   // R7: low gate forces the periodic modes high
   p_gate_forces_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (periodic && !gate_in && host_quiet) |=> out_o);

   // R9 and R10: strobes last exactly one tick
   p_strobe_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == MD_SW_STROBE || mode_q == MD_HW_STROBE) && !out_o && cnt_tick
       && host_quiet) |=> out_o);

   // R11: a loaded BCD count keeps decimal digits
   p_bcd_digits_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bcd_q && run_q) |-> digits_ok(count_o));

endmodule

// File: tb/ctr_channel_test.sv
module ctr_channel_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_tick = 1'b0;
   logic        gate_in = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [2:0]  cfg_mode = 3'd0;
   logic        cfg_bcd = 1'b0;
   logic        ld_lo = 1'b0;
   logic        ld_hi = 1'b0;
   logic [7:0]  ld_byte = 8'd0;
   logic [15:0] count_o;
   logic        out_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ctr_channel uut (
      .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .gate_in(gate_in),
      .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd),
      .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_byte(ld_byte),
      .count_o(count_o), .out_o(out_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_tick();
      @(negedge clk) cnt_tick = 1'b1;
      @(negedge clk) cnt_tick = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) do_tick();
   endtask

   task automatic write_mode(input logic [2:0] m, input logic b);
      @(negedge clk) begin cfg_wr = 1'b1; cfg_mode = m; cfg_bcd = b; end
      @(negedge clk) cfg_wr = 1'b0;
   endtask

   task automatic write_lo(input logic [7:0] v);
      @(negedge clk) begin ld_lo = 1'b1; ld_byte = v; end
      @(negedge clk) ld_lo = 1'b0;
   endtask

   task automatic write_hi(input logic [7:0] v);
      @(negedge clk) begin ld_hi = 1'b1; ld_byte = v; end
      @(negedge clk) ld_hi = 1'b0;
   endtask

   task automatic write_count(input logic [15:0] v);
      write_lo(v[7:0]);
      write_hi(v[15:8]);
   endtask

   task automatic set_gate(input logic v);
      @(negedge clk) gate_in = v;
      @(negedge clk);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   task automatic test_reset();
      chk("R1 out after reset", out_o, 1);
      chk("R1 count after reset", count_o, 0);
      ticks(2);
      chk("R1 idle count", count_o, 0);
   endtask

   task automatic test_level();
      set_gate(1'b1);
      write_mode(3'd0, 1'b0);
      chk("R2 out after mode", out_o, 0);
      write_count(16'd5);
      ticks(5);
      chk("R2 count before tc", count_o, 1);
      chk("R2 out before tc", out_o, 0);
      ticks(1);
      chk("R2 out at tc", out_o, 1);
      ticks(1);
      chk("R2 keeps counting", count_o, 16'hFFFF);
      chk("R2 stays high", out_o, 1);
   endtask

   task automatic test_level_rewrite();
      write_lo(8'd3);
      ticks(2);
      chk("R3 frozen by low byte", count_o, 16'hFFFF);
      write_hi(8'd0);
      chk("R3 out low on commit", out_o, 0);
      ticks(3);
      chk("R3 new count running", count_o, 1);
      chk("R3 out before tc", out_o, 0);
      ticks(1);
      chk("R3 out at tc", out_o, 1);
   endtask

   task automatic test_level_gate();
      write_mode(3'd0, 1'b0);
      write_count(16'd3);
      set_gate(1'b0);
      ticks(4);
      chk("R4 held by low gate", count_o, 3);
      set_gate(1'b1);
      ticks(2);
      chk("R4 resumes", count_o, 1);
      chk("R4 out before tc", out_o, 0);
      ticks(1);
      chk("R4 out at tc", out_o, 1);
   endtask

   task automatic test_one_shot();
      set_gate(1'b0);
      write_mode(3'd1, 1'b0);
      chk("R5 idles high", out_o, 1);
      write_count(16'd4);
      ticks(2);
      chk("R5 no trigger no pulse", out_o, 1);
      set_gate(1'b1);
      ticks(1);
      chk("R5 low after trigger", out_o, 0);
      chk("R5 loaded", count_o, 4);
      ticks(3);
      chk("R5 low for N ticks", out_o, 0);
      ticks(1);
      chk("R5 rises after N", out_o, 1);
      set_gate(1'b0);
      set_gate(1'b1);
      ticks(3);
      chk("R5 second pulse count", count_o, 2);
      set_gate(1'b0);
      set_gate(1'b1);
      ticks(1);
      chk("R5 retrigger reloads", count_o, 4);
      write_count(16'd2);
      ticks(3);
      chk("R5 pulse unchanged by write", count_o, 1);
      chk("R5 still low", out_o, 0);
      ticks(1);
      chk("R5 end of retriggered pulse", out_o, 1);
   endtask

   task automatic test_rate();
      logic [5:0] seen;
      set_gate(1'b1);
      write_mode(3'd2, 1'b0);
      write_count(16'd3);
      for (int i = 0; i < 4; i++) begin
         do_tick();
         seen[i] = out_o;
      end
      chk("R6 period 3 pattern", {28'd0, seen[3:0]}, 4'b1011);
      write_count(16'd4);
      for (int i = 0; i < 6; i++) begin
         do_tick();
         seen[i] = out_o;
      end
      chk("R6 reload next period", {26'd0, seen}, 6'b011101);
      // R7: gate low forces high
      set_gate(1'b0);
      chk("R7 gate low forces high", out_o, 1);
      ticks(2);
      chk("R7 count held", count_o, 1);
      set_gate(1'b1);
      ticks(1);
      chk("R7 rising gate reloads", count_o, 4);
      ticks(3);
      chk("R7 pulse after restart", out_o, 0);
   endtask

   task automatic test_square();
      logic [8:0] seen;
      set_gate(1'b1);
      write_mode(3'd3, 1'b0);
      write_count(16'd4);
      for (int i = 0; i < 8; i++) begin
         do_tick();
         seen[i] = out_o;
      end
      chk("R8 even square", {24'd0, seen[7:0]}, 8'b00110011);
      write_mode(3'd3, 1'b0);
      write_count(16'd5);
      for (int i = 0; i < 9; i++) begin
         do_tick();
         seen[i] = out_o;
      end
      chk("R8 odd square", {23'd0, seen}, 9'b011100111);
   endtask

   task automatic test_sw_strobe();
      set_gate(1'b1);
      write_mode(3'd4, 1'b0);
      chk("R9 high after mode", out_o, 1);
      write_count(16'd3);
      ticks(4);
      chk("R9 strobe low", out_o, 0);
      chk("R9 count at tc", count_o, 0);
      ticks(1);
      chk("R9 strobe one tick", out_o, 1);
      write_count(16'd2);
      set_gate(1'b0);
      ticks(3);
      chk("R9 gate inhibits", count_o, 2);
      set_gate(1'b1);
      ticks(2);
      chk("R9 strobe after inhibit", out_o, 0);
   endtask

   task automatic test_hw_strobe();
      set_gate(1'b0);
      write_mode(3'd5, 1'b0);
      write_count(16'd3);
      ticks(2);
      chk("R10 waits for trigger", out_o, 1);
      set_gate(1'b1);
      ticks(4);
      chk("R10 strobe low", out_o, 0);
      ticks(1);
      chk("R10 strobe one tick", out_o, 1);
      set_gate(1'b0);
      set_gate(1'b1);
      ticks(2);
      set_gate(1'b0);
      set_gate(1'b1);
      ticks(1);
      chk("R10 retrigger reloads", count_o, 3);
      ticks(2);
      chk("R10 high before tc", out_o, 1);
      ticks(1);
      chk("R10 strobe after retrigger", out_o, 0);
   endtask

   task automatic test_bcd();
      set_gate(1'b1);
      write_mode(3'd0, 1'b1);
      write_count(16'h0010);
      ticks(2);
      chk("R11 decimal 10 to 9", count_o, 16'h0009);
      ticks(9);
      chk("R11 decimal tc", out_o, 1);
      write_count(16'h0100);
      ticks(2);
      chk("R11 decimal borrow", count_o, 16'h0099);
      write_count(16'h0000);
      ticks(2);
      chk("R11 zero is 10000", count_o, 16'h9999);
      chk("R11 no tc from zero", out_o, 0);
      write_mode(3'd0, 1'b0);
      write_count(16'h0000);
      ticks(2);
      chk("R11 zero is 65536", count_o, 16'hFFFF);
   endtask

   task automatic test_alias();
      set_gate(1'b1);
      write_mode(3'd6, 1'b0);
      write_count(16'd3);
      ticks(3);
      chk("R12 code 6 pulse", out_o, 0);
      ticks(1);
      chk("R12 code 6 reload", out_o, 1);
      write_mode(3'd7, 1'b0);
      write_count(16'd4);
      ticks(2);
      chk("R12 code 7 high half", out_o, 1);
      ticks(1);
      chk("R12 code 7 low half", out_o, 0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_level();
      test_level_rewrite();
      test_level_gate();
      test_one_shot();
      test_rate();
      test_square();
      test_sw_strobe();
      test_hw_strobe();
      test_bcd();
      test_alias();
      summary();
   end
endmodule